// File: doc/BRIEF.md
# Flash Command State Controller

This block models the command and sequencing logic of a NOR-style flash array, with the array held in a small on-chip memory. A host drives it through chip enable, write enable, output enable, an address and a 16-bit data word. Multi-write command sequences start timed word programs and sector erases. Progress is visible in two ways: a ready/busy output, and a status word that replaces array data on reads while an operation is running.

An erase can be suspended so that the host can read other sectors or program them. A program can be suspended so that the host can read other sectors. A bypass mode cuts each program down to two writes. A write-protect pin locks one boundary sector, and a hardware reset abandons whatever is in flight.

The address splits into a sector number, taken from the top `SECT_W` bits, and a word offset, taken from the rest. A host write is one clock cycle with `ce_n` and `we_n` both low. A host read is a cycle with `ce_n` and `oe_n` low and `we_n` high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Command codes are compared on `wdata[7:0]`, and "at 0x555" or "at 0x2AA" refers to `addr[10:0]`. A standard program is four writes: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the data word at the target address. The stored word becomes the old word bitwise AND the new data.
- R2: The sequence 0xAA at 0x555, 0x55 at 0x2AA, 0x20 at 0x555 enters bypass mode. In bypass, a program is 0xA0 at any address followed by the data write. The writes 0x90 then 0x00 leave bypass, after which a two-write program does nothing.
- R3: `ready` goes low on the clock edge that accepts the last write of a program or erase. It stays low for exactly `PROG_CYC` cycles for a program and `ERASE_CYC` cycles for an erase, counted from that edge.
- R4: A read while `ready` is low returns a status word with every bit zero except two. Bit 7 is the complement of bit 7 of the data being programmed, and is 0 during an erase. Bit 6 starts at 0 after reset and inverts after every read cycle taken while busy. Once the operation ends, reads return array data.
- R5: The erase sequence is 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x30 at any address in the target sector. Every word of that sector becomes 0xFFFF. Other sectors are unchanged.
- R6: A write of 0xB0 during a running erase makes `ready` high from the next cycle. While the erase is suspended, reads of other sectors return array data and programs to other sectors run normally. A program aimed at the suspended sector is ignored. A write of 0x30 from the idle command state resumes the erase, which then finishes.
- R7: A write of 0xB0 during a running program suspends it, and `ready` goes high. While suspended, reads of other sectors return array data and any program attempt is ignored. A write of 0x30 resumes the program, which then completes with the correct value. The program and erase suspend states are never both set.
- R8: With `wp_n` low, the boundary sector is protected: the highest sector when `WP_TOP` is 1, the lowest otherwise. A program or erase aimed at it holds `ready` low for exactly `PROT_CYC` cycles and changes nothing. Other sectors work normally.
- R9: A write that does not fit the expected next step of a sequence (0xF0, for example) returns the decoder to its idle state. Later writes must then start a sequence from the beginning. Bypass mode, if active, is kept.
- R10: While `rst_n` is low, any operation is abandoned and its pending array update is dropped. Suspend, bypass and sequence state are cleared, and `ready` is high. `rdata` is zero whenever no read is taking place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Boundary-sector write protect, active low |
| addr | input | ADDR_W | Word address; top SECT_W bits pick the sector |
| wdata | input | 16 | Command or program data |
| rdata | output | 16 | Array data or status word, zero when not reading |
| ready | output | 1 | High when no program, erase or rejection hold is running |

## Verification
A command write is taken on the rising edge inside its one-cycle strobe. The bench samples at the following falling edge and counts falling edges from there. On that count `ready` must still be low at `PROG_CYC-1`, `ERASE_CYC-1` or `PROT_CYC-1`, and high one cycle later. Suspend and resume take effect at that first falling edge, and rejected writes are checked there too. Read data is combinational from registered state, so each read is sampled one time unit after the address is applied. The status bit 6 is expected to change between two reads that are separated by a clock edge.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 600,
  parameter int PROT_CYC  = 3,
  parameter int WP_TOP    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              ready
);
  localparam int WORDS   = 1 << ADDR_W;
  localparam int OFF_W   = ADDR_W - SECT_W;
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int TW0     = $clog2(CNT_MAX + 1);
  localparam int TW      = (TW0 > OFF_W) ? TW0 : OFF_W;
  localparam logic [SECT_W-1:0] WP_SECT = (WP_TOP != 0) ? {SECT_W{1'b1}} : {SECT_W{1'b0}};

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PA, S_E1, S_E2, S_E3, S_BX} seq_t;

  logic [15:0] mem [WORDS];
  seq_t seq;
  logic byp, tog;
  logic prog_act, psusp, ers_act, esusp;
  logic [ADDR_W-1:0] pa;
  logic [15:0] pd;
  logic [SECT_W-1:0] es;
  logic [TW-1:0] ptmr, etmr, pcnt;

  wire wr   = !ce_n && !we_n;
  wire rd   = !ce_n && !oe_n && we_n;
  wire [7:0] cmd = wdata[7:0];
  wire a555 = addr[10:0] == 11'h555;
  wire a2aa = addr[10:0] == 11'h2AA;
  wire [SECT_W-1:0] sect = addr[ADDR_W-1 -: SECT_W];
  wire prot_hit = !wp_n && (sect == WP_SECT);
  wire prun = prog_act && !psusp;
  wire erun = ers_act && !esusp;
  wire busy = prun || erun || (pcnt != '0);
  wire dq7  = prun ? ~pd[7] : 1'b0;

  assign ready = !busy;
  assign rdata = !rd ? 16'h0 : busy ? {8'h00, dq7, tog, 6'h00} : mem[addr];

  always_ff @(posedge clk) begin
    if (rst_n) begin
      if (prun && ptmr == '0) mem[pa] <= mem[pa] & pd;
      if (erun) mem[{es, etmr[OFF_W-1:0]}] <= 16'hFFFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= S_IDLE; byp <= 1'b0; tog <= 1'b0;
      prog_act <= 1'b0; psusp <= 1'b0; ers_act <= 1'b0; esusp <= 1'b0;
      pa <= '0; pd <= '0; es <= '0; ptmr <= '0; etmr <= '0; pcnt <= '0;
    end else begin
      if (rd && busy) tog <= ~tog;
      if (pcnt != '0) pcnt <= pcnt - 1'b1;
      if (prun) begin
        if (ptmr == '0) prog_act <= 1'b0;
        else ptmr <= ptmr - 1'b1;
      end
      if (erun) begin
        if (etmr == '0) ers_act <= 1'b0;
        else etmr <= etmr - 1'b1;
      end
      if (wr && busy) begin
        seq <= S_IDLE;
        if (cmd == 8'hB0) begin
          if (prun && !esusp && ptmr != '0) psusp <= 1'b1;
          else if (erun && etmr != '0) esusp <= 1'b1;
        end
      end else if (wr) begin
        seq <= S_IDLE;
        case (seq)
          S_IDLE: begin
            if (cmd == 8'h30) begin
              if (psusp) psusp <= 1'b0;
              else if (esusp) esusp <= 1'b0;
            end else if (byp) begin
              if (cmd == 8'hA0) seq <= S_PA;
              else if (cmd == 8'h90) seq <= S_BX;
            end else if (cmd == 8'hAA && a555) seq <= S_U1;
          end
          S_U1: if (cmd == 8'h55 && a2aa) seq <= S_U2;
          S_U2: begin
            if (a555 && cmd == 8'hA0) seq <= S_PA;
            else if (a555 && cmd == 8'h80) seq <= S_E1;
            else if (a555 && cmd == 8'h20) byp <= 1'b1;
          end
          S_PA: begin
            if (psusp || (esusp && sect == es)) begin
            end else if (prot_hit) pcnt <= TW'(PROT_CYC);
            else begin
              prog_act <= 1'b1; pa <= addr; pd <= wdata; ptmr <= TW'(PROG_CYC - 1);
            end
          end
          S_E1: if (cmd == 8'hAA && a555) seq <= S_E2;
          S_E2: if (cmd == 8'h55 && a2aa) seq <= S_E3;
          S_E3: begin
            if (cmd != 8'h30 || psusp || esusp) begin
            end else if (prot_hit) pcnt <= TW'(PROT_CYC);
            else begin
              ers_act <= 1'b1; es <= sect; etmr <= TW'(ERASE_CYC - 1);
            end
          end
          S_BX: if (cmd == 8'h00) byp <= 1'b0;
          default: seq <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        we_n,
  input logic        oe_n,
  input logic        ready,
  input logic [15:0] rdata,
  input logic        psusp,
  input logic        esusp,
  input logic        byp
);
  wire wr = !ce_n && !we_n;
  wire rd = !ce_n && !oe_n && we_n;

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (ready && !psusp && !esusp && !byp));

  a_r3_busy_starts_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr));

  a_r4_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'h00));

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !ready && $past(rd && !ready)) |-> (rdata[6] != $past(rdata[6])));

  a_r7_single_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    !(psusp && esusp));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .ready(ready), .rdata(rdata), .psusp(psusp), .esusp(esusp), .byp(byp)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int PROG_CYC = 12, ERASE_CYC = 600, PROT_CYC = 3;
  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [10:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic ready;
  logic [15:0] mdl [2048];
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .PROT_CYC(PROT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready));

  function automatic logic [15:0] prog_exp(input logic [15:0] old_w, input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !ready; i++) @(negedge clk);
  endtask

  task automatic prog4(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'hA0); wr(a, d);
  endtask

  task automatic erase(input logic [1:0] s);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h80);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr({s, 9'h000}, 16'h30);
  endtask

  task automatic byp_enter();
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h20);
  endtask

  task automatic byp_exit();
    wr(11'h000, 16'h90); wr(11'h000, 16'h00);
  endtask

  task automatic chk_word(input string tag, input logic [10:0] a);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, mdl[a]);
  endtask

  task automatic chk_sector(input string tag, input logic [1:0] s);
    logic [15:0] d;
    int bad = 0;
    for (int i = 0; i < 512; i++) begin
      rd({s, i[8:0]}, d);
      if (d !== mdl[{s, i[8:0]}]) bad++;
    end
    chk(tag, 16'(bad), 16'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d0, d1;
    logic [10:0] a;
    logic [15:0] v;
    void'($urandom(32'd2024));
    skip(5);
    chk("R10 reset ready", 16'(ready), 16'h1);
    chk("R10 rdata idle zero", rdata, 16'h0);
    @(negedge clk); rst_n = 1;

    for (int s = 0; s < 4; s++) begin
      erase(2'(s));
      if (s == 0) begin
        skip(ERASE_CYC - 1); chk("R3 erase busy at last cycle", 16'(ready), 16'h0);
        skip(1);             chk("R3 erase ready after ERASE_CYC", 16'(ready), 16'h1);
      end
      wait_ready();
      for (int i = 0; i < 512; i++) mdl[{s[1:0], i[8:0]}] = 16'hFFFF;
    end
    chk_sector("R5 sector0 erased", 2'd0);
    chk_sector("R5 sector3 erased", 2'd3);

    prog4(11'h012, 16'h5A3C);
    rd(11'h012, d0); rd(11'h012, d1);
    chk("R4 status first read", d0, 16'h0080);
    chk("R4 status second read", d1, 16'h00C0);
    wait_ready();
    mdl[11'h012] = prog_exp(mdl[11'h012], 16'h5A3C);
    chk_word("R4 true data after program", 11'h012);
    prog4(11'h012, 16'hF0F0);
    skip(PROG_CYC - 1); chk("R3 program busy at last cycle", 16'(ready), 16'h0);
    skip(1);            chk("R3 program ready after PROG_CYC", 16'(ready), 16'h1);
    mdl[11'h012] = prog_exp(mdl[11'h012], 16'hF0F0);
    chk_word("R1 AND of old and new", 11'h012);

    for (int it = 0; it < 30; it++) begin
      a = 11'($urandom_range(0, 2047));
      v = 16'($urandom);
      if ($urandom_range(0, 1) == 1) prog4(a, v);
      else begin byp_enter(); wr(11'h000, 16'hA0); wr(a, v); end
      wait_ready();
      byp_exit();
      mdl[a] = prog_exp(mdl[a], v);
      chk_word("R1 R2 random program", a);
    end

    byp_enter();
    wr(11'h100, 16'hA0); wr(11'h101, 16'h0F00);
    chk("R2 bypass program starts", 16'(ready), 16'h0);
    wait_ready(); mdl[11'h101] = prog_exp(mdl[11'h101], 16'h0F00);
    chk_word("R2 bypass program value", 11'h101);
    wr(11'h000, 16'h77);
    wr(11'h100, 16'hA0); wr(11'h102, 16'h00F0);
    chk("R9 bypass kept after stray write", 16'(ready), 16'h0);
    wait_ready(); mdl[11'h102] = prog_exp(mdl[11'h102], 16'h00F0);
    chk_word("R9 bypass program after stray", 11'h102);
    byp_exit();
    wr(11'h100, 16'hA0); wr(11'h103, 16'h0000);
    chk("R2 bypass exited", 16'(ready), 16'h1);
    chk_word("R2 no program after exit", 11'h103);

    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h12); wr(11'h2AA, 16'h55); wr(11'h555, 16'hA0);
    wr(11'h104, 16'h1200);
    chk("R9 broken sequence ignored", 16'(ready), 16'h1);
    chk_word("R9 word unchanged", 11'h104);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'hF0); wr(11'h105, 16'h0000);
    chk("R9 0xF0 aborts sequence", 16'(ready), 16'h1);

    prog4(11'h700, 16'h1111); wait_ready(); mdl[11'h700] = prog_exp(mdl[11'h700], 16'h1111);
    wp_n = 0;
    prog4(11'h701, 16'h0000);
    skip(PROT_CYC - 1); chk("R8 protected program busy", 16'(ready), 16'h0);
    skip(1);            chk("R8 protected program released", 16'(ready), 16'h1);
    chk_word("R8 protected word unchanged", 11'h701);
    erase(2'd3);
    skip(PROT_CYC); chk("R8 protected erase released", 16'(ready), 16'h1);
    chk_word("R8 protected sector not erased", 11'h700);
    prog4(11'h020, 16'h0F0F);
    skip(PROT_CYC); chk("R8 other sector still programs", 16'(ready), 16'h0);
    wait_ready(); mdl[11'h020] = prog_exp(mdl[11'h020], 16'h0F0F);
    chk_word("R8 other sector value", 11'h020);
    wp_n = 1;

    prog4(11'h2A0, 16'h0F0F); wait_ready(); mdl[11'h2A0] = prog_exp(mdl[11'h2A0], 16'h0F0F);
    erase(2'd1);
    rd(11'h2A0, d0);
    chk("R4 erase status bit7 zero", d0 & 16'hFFBF, 16'h0000);
    skip(100);
    wr(11'h000, 16'hB0);
    chk("R6 erase suspended ready", 16'(ready), 16'h1);
    chk_word("R6 read other sector", 11'h012);
    prog4(11'h013, 16'h00FF);
    chk("R6 program other sector runs", 16'(ready), 16'h0);
    wait_ready(); mdl[11'h013] = prog_exp(mdl[11'h013], 16'h00FF);
    chk_word("R6 program other sector value", 11'h013);
    prog4(11'h2A1, 16'h0000);
    chk("R6 program in erasing sector ignored", 16'(ready), 16'h1);
    wr(11'h000, 16'h30);
    chk("R6 erase resumed", 16'(ready), 16'h0);
    wait_ready();
    for (int i = 0; i < 512; i++) mdl[{2'd1, i[8:0]}] = 16'hFFFF;
    chk_sector("R6 R5 sector1 fully erased", 2'd1);
    chk_word("R5 sector0 untouched", 11'h013);

    prog4(11'h420, 16'h1357);
    wr(11'h000, 16'hB0);
    chk("R7 program suspended ready", 16'(ready), 16'h1);
    chk_word("R7 read other sector", 11'h012);
    prog4(11'h014, 16'h0000);
    chk("R7 program rejected while suspended", 16'(ready), 16'h1);
    chk_word("R7 rejected word unchanged", 11'h014);
    wr(11'h000, 16'h30);
    chk("R7 program resumed", 16'(ready), 16'h0);
    wait_ready(); mdl[11'h420] = prog_exp(mdl[11'h420], 16'h1357);
    chk_word("R7 program completed", 11'h420);

    byp_enter();
    wr(11'h000, 16'hA0); wr(11'h030, 16'h0000);
    skip(3);
    @(negedge clk); rst_n = 0;
    skip(2);
    chk("R10 ready during reset", 16'(ready), 16'h1);
    rst_n = 1;
    chk_word("R10 aborted program left word", 11'h030);
    wr(11'h000, 16'hA0); wr(11'h030, 16'h0000);
    chk("R10 bypass cleared by reset", 16'(ready), 16'h1);
    chk_word("R10 word still unchanged", 11'h030);

    summary();
    $finish;
  end
endmodule